// File: doc/BRIEF.md
# Masked Event-to-Interrupt Line Mapper

This block sits beside an Ethernet MAC and gathers its event pulses into one 32-bit latched event register. Thirteen bit positions in the upper part of that register are defined, and each of them has its own interrupt line. The transmit engine, the receive engine and the control side raise events with one-cycle set pulses. The bits stay set until software clears them by writing ones to the event register.

A 32-bit mask register selects which events may reach their lines. A line is high when its event bit and its mask bit are both set. The lines are registered, so a line follows the masked value one clock after the register state changes. The lines are not numbered in event-bit order. Each line has a fixed, non-sequential assignment that the interrupt controller depends on.

A small register port gives access to three words: the event register, the mask register and a transmit control word. When software writes the transmit control word with bit 0 set, it is asking for a graceful stop. The stop is treated as complete straight away, so the write raises the graceful-stop-complete event on the same edge.

Top module: `irq_line_mapper`

## Requirements
- R1: After reset the event register, the mask register and the transmit control word read as zero, and all 13 interrupt lines are low.
- R2: Event bits sit at bits 31 down to 19 as follows: 31 heartbeat error, 30 babbling receive, 29 babbling transmit, 28 graceful stop complete, 27 transmit frame, 26 transmit buffer, 25 receive frame, 24 receive buffer, 23 management done, 22 bus error, 21 late collision, 20 retry limit, 19 underrun. A one on `eventSet[b]` latches event bit b. Set pulses on bits 18..0 are ignored, and those bits always read as zero.
- R3: Each interrupt line watches a fixed event bit. Lines 0 to 12 watch bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29 and 30, in that order.
- R4: A line is high exactly when its event bit and its mask bit are both 1. The lines are registered: a line changes on the clock edge after the edge that changed the event or mask register.
- R5: A write to address 0 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A write to address 1 stores all 32 bits of the mask register, and a read returns them exactly.
- R7: A write to address 2 stores the transmit control word, which reads back exactly. When bit 0 of the written value is 1, event bit 28 is set on the same edge. When bit 0 is 0, no event is raised.
- R8: When a set pulse and a write-one-to-clear hit the same event bit in the same cycle, the bit ends up set.
- R9: Address 3 reads as zero. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Word address: 0 event, 1 mask, 2 transmit control |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| eventSet | input | 32 | Set pulses, one per event bit position |
| irqLines | output | 13 | Level-sensitive interrupt lines |

## Verification
The assertions take two things for granted. First, `eventSet` and the register port are driven synchronously. Second, a graceful-stop request on address 2 never arrives in the same cycle as a clear on address 0, which holds because there is only one write port. The write-one-to-clear property is checked only in cycles with no set pulse. That lets it stay exact without modelling the priority rule, which has a property of its own. The stimulus drives every input on the falling edge. It changes only one register at a time, except in the priority test, where a set and a clear deliberately meet on one edge.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_LINES = 13;
  localparam int EVT_LSB   = 19;
  localparam logic [DATA_W-1:0] EVT_VALID = {{NUM_LINES{1'b1}}, {EVT_LSB{1'b0}}};
  localparam int GRACEFUL_BIT = 28;

  // Strobes from control to datapath
  typedef struct packed {
    logic evtClrWr;
    logic maskWr;
    logic txCtlWr;
    logic gracefulReq;
  } regStrobe_t;

  // Event bit watched by each interrupt line
  function automatic int lineBit(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_map_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] ADDR_EVENT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TXCTL = ADDR_W'(2);

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      strobe.evtClrWr    = (regAddr == ADDR_EVENT);
      strobe.maskWr      = (regAddr == ADDR_MASK);
      strobe.txCtlWr     = (regAddr == ADDR_TXCTL);
      strobe.gracefulReq = (regAddr == ADDR_TXCTL) && wrBit0;
    end
  end

endmodule

// File: rtl/irq_reg_datapath.sv
module irq_reg_datapath
  import irq_map_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] eventSet,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] eventQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [NUM_LINES-1:0] irqLines
);

  logic [DATA_W-1:0] txCtlQ;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] eventNext;

  always_comb begin
    setVec = eventSet;
    if (strobe.gracefulReq) setVec[GRACEFUL_BIT] = 1'b1;
    clrVec    = strobe.evtClrWr ? wrData : '0;
    eventNext = ((eventQ & ~clrVec) | setVec) & EVT_VALID;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventQ <= '0;
      maskQ  <= '0;
      txCtlQ <= '0;
    end else begin
      eventQ <= eventNext;
      if (strobe.maskWr)  maskQ  <= wrData;
      if (strobe.txCtlWr) txCtlQ <= wrData;
    end
  end

  generate
    for (genvar k = 0; k < NUM_LINES; k++) begin : gLine
      localparam int BIT = lineBit(k);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqLines[k] <= 1'b0;
        else       irqLines[k] <= eventQ[BIT] & maskQ[BIT];
      end
    end
  endgenerate

  always_comb begin
    case (rdAddr)
      ADDR_W'(0): rdData = eventQ;
      ADDR_W'(1): rdData = maskQ;
      ADDR_W'(2): rdData = txCtlQ;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_line_mapper.sv
module irq_line_mapper
  import irq_map_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       eventSet,
  output logic [12:0]       irqLines
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] eventQ;
  logic [DATA_W-1:0] maskQ;

  irq_reg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrBit0  (regWrData[0]),
    .strobe  (strobe)
  );

  irq_reg_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .eventSet (eventSet),
    .rdAddr   (regAddr),
    .rdData   (regRdData),
    .eventQ   (eventQ),
    .maskQ    (maskQ),
    .irqLines (irqLines)
  );

endmodule

// File: rtl/irq_line_mapper_chk.sv
module irq_line_mapper_chk
  import irq_map_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       eventSet,
  input logic [12:0]       irqLines,
  input logic [31:0]       eventQ,
  input logic [31:0]       maskQ
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (eventQ & ~EVT_VALID) == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eventSet & EVT_VALID) != '0 |=>
      (eventQ & $past(eventSet & EVT_VALID)) == $past(eventSet & EVT_VALID));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(0) && eventSet == '0) |=>
      ((eventQ & $past(regWrData)) == '0) &&
      ((eventQ & ~$past(regWrData)) == ($past(eventQ) & ~$past(regWrData))));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(1)) |=> maskQ == $past(regWrData));

  assert_graceful_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(2) && regWrData[0]) |=> eventQ[GRACEFUL_BIT]);

  generate
    for (genvar k = 0; k < NUM_LINES; k++) begin : gLineChk
      localparam int BIT = lineBit(k);
      // R3 and R4: line follows masked event one edge later
      assert_line_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
        irqLines[k] == $past(eventQ[BIT] & maskQ[BIT]));
    end
  endgenerate

endmodule

bind irq_line_mapper irq_line_mapper_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .eventSet  (eventSet),
  .irqLines  (irqLines),
  .eventQ    (eventQ),
  .maskQ     (maskQ)
);

// File: tb/tb_irq_line_mapper.sv
module tb_irq_line_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] eventSet = '0;
  logic [12:0] irqLines;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] VALID = 32'hFFF8_0000;

  irq_line_mapper dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eventSet(eventSet),
    .irqLines(irqLines)
  );

  always #5 clk = ~clk;

  // Bench copy of the line map from R3
  function automatic int benchBit(input int k);
    int tbl [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return tbl[k];
  endfunction

  function automatic logic [12:0] expLines(input logic [31:0] ev, input logic [31:0] mk);
    logic [12:0] r = '0;
    for (int k = 0; k < 13; k++) r[k] = ev[benchBit(k)] & mk[benchBit(k)];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [31:0] s);
    eventSet = s;
    step();
    eventSet = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ev;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, rd); chk("R1 event", rd, 32'h0);
    readReg(2'd1, rd); chk("R1 mask", rd, 32'h0);
    readReg(2'd2, rd); chk("R1 txctl", rd, 32'h0);
    chk("R1 lines", {19'h0, irqLines}, 32'h0);

    // R6 mask all ones
    busWrite(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, rd); chk("R6 mask ones", rd, 32'hFFFF_FFFF);

    // Sweep every event bit: R2 latch, R3 map, R5 clear
    for (int b = 19; b < 32; b++) begin
      pulse(32'h1 << b);
      readReg(2'd0, rd); chk("R2 latch", rd, 32'h1 << b);
      step();
      chk("R3 line map", {19'h0, irqLines}, {19'h0, expLines(32'h1 << b, 32'hFFFF_FFFF)});
      busWrite(2'd0, 32'h1 << b);
      readReg(2'd0, rd); chk("R5 clear single", rd, 32'h0);
      step();
      chk("R4 line drops", {19'h0, irqLines}, 32'h0);
    end

    // R2 reserved set pulses ignored
    pulse(32'h0007_FFFF);
    readReg(2'd0, rd); chk("R2 reserved", rd, 32'h0);
    step();
    chk("R2 reserved lines", {19'h0, irqLines}, 32'h0);

    // R4 mask sweep with all events set
    pulse(VALID);
    for (int k = 0; k < 13; k++) begin
      busWrite(2'd1, 32'h1 << benchBit(k));
      step();
      chk("R4 single mask", {19'h0, irqLines}, 32'h1 << k);
      busWrite(2'd1, ~(32'h1 << benchBit(k)));
      step();
      chk("R4 all but one", {19'h0, irqLines}, {19'h0, 13'h1FFF & ~(13'h1 << k)});
    end

    // R6 pattern readback
    busWrite(2'd1, 32'hA5A5_5A5A);
    readReg(2'd1, rd); chk("R6 pattern a", rd, 32'hA5A5_5A5A);
    busWrite(2'd1, 32'h0000_0001);
    readReg(2'd1, rd); chk("R6 pattern b", rd, 32'h0000_0001);
    step();
    chk("R4 reserved mask bit", {19'h0, irqLines}, 32'h0);

    // R5 partial clear and zero write
    busWrite(2'd0, 32'hAAAA_AAAA);
    ev = VALID & ~32'hAAAA_AAAA;
    readReg(2'd0, rd); chk("R5 partial", rd, ev);
    busWrite(2'd0, 32'h0);
    readReg(2'd0, rd); chk("R5 zero write", rd, ev);

    // R4 latency: line rises one edge after mask write
    busWrite(2'd0, 32'hFFFF_FFFF);
    busWrite(2'd1, 32'h0);
    pulse(32'h1 << 27);
    step();
    chk("R4 masked off", {19'h0, irqLines}, 32'h0);
    busWrite(2'd1, 32'h1 << 27);
    chk("R4 not yet", {19'h0, irqLines}, 32'h0);
    step();
    chk("R4 one edge later", {19'h0, irqLines}, 32'h1);

    // R8 set wins over same-cycle clear
    busWrite(2'd0, 32'hFFFF_FFFF);
    pulse((32'h1 << 26) | (32'h1 << 25));
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = (32'h1 << 26) | (32'h1 << 25);
    eventSet = 32'h1 << 26;
    step();
    regWrEn = 1'b0; regWrData = '0; eventSet = '0;
    readReg(2'd0, rd); chk("R8 set priority", rd, 32'h1 << 26);

    // R7 graceful stop request
    busWrite(2'd0, 32'hFFFF_FFFF);
    busWrite(2'd1, 32'hFFFF_FFFF);
    busWrite(2'd2, 32'h0000_0002);
    readReg(2'd0, rd); chk("R7 no request", rd, 32'h0);
    readReg(2'd2, rd); chk("R7 readback a", rd, 32'h2);
    busWrite(2'd2, 32'h0000_0001);
    readReg(2'd0, rd); chk("R7 event raised", rd, 32'h1 << 28);
    readReg(2'd2, rd); chk("R7 readback b", rd, 32'h1);
    step();
    chk("R7 line 9", {19'h0, irqLines}, 32'h1 << 9);

    // R9 unmapped address
    busWrite(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, rd); chk("R9 read zero", rd, 32'h0);
    readReg(2'd0, rd); chk("R9 event kept", rd, 32'h1 << 28);
    readReg(2'd1, rd); chk("R9 mask kept", rd, 32'hFFFF_FFFF);
    readReg(2'd2, rd); chk("R9 txctl kept", rd, 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule